// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds one logical register that exists once per hardware unit, arranged as a grid of groups and instances. All copies answer at a single bus address. A second address holds a steering selector with three fields: a group ID, an instance ID and a broadcast flag. The selector decides which copies a bus access reaches.

With the broadcast flag set, a write to the shared address loads every present copy. With the flag clear, only the copy named by the steering IDs is loaded. Reads always return exactly one copy, the steered one, whatever the flag says. A per-copy availability mask marks units that are fused off or power-gated. Accesses steered to an absent copy are terminated: reads return zero and unicast writes are dropped. Broadcast writes skip absent copies.

The bus is a plain single-cycle register port. Read data is registered and follows the address of the previous cycle, so every cycle is also a read of the address presented.

Top module: `rrb_bank`

## Requirements
- R1: After reset the selector reads back with the broadcast flag set and both IDs zero (value 0x0001_0000), and every stored copy is zero.
- R2: A write to the shared address with the broadcast flag set loads the write data into every copy whose availability bit is 1.
- R3: A broadcast write leaves every copy whose availability bit is 0 at its previous value.
- R4: A write to the shared address with the broadcast flag clear loads only the copy at index group*NUM_INST+instance; all other copies keep their values.
- R5: A unicast write steered to a copy whose availability bit is 0 changes no copy.
- R6: A read of the shared address returns the steered copy, both with the broadcast flag set and with it clear.
- R7: A read of the shared address steered to a copy whose availability bit is 0 returns zero.
- R8: The selector keeps the instance ID in bits [7:0], the group ID in bits [15:8] and the broadcast flag in bit 16; only the low log2 bits of each ID are kept, all other read-back bits are zero, and a selector write steers the very next access.
- R9: bus_rdata shows, one clock after an address is presented, the data at that address; addresses other than the two bank addresses read zero and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address of this cycle |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | DATA_W | Write data |
| avail_mask | input | NUM_GROUPS*NUM_INST | 1 = copy present and powered; bit index group*NUM_INST+instance |
| bus_rdata | output | DATA_W | Registered read data of the previous cycle's address |

## Verification
The assertions watch every cycle that write enables never reach an absent copy, that a unicast write touches at most the steered copy, that a broadcast write lands in every present copy, and that a terminated read produces zero while a normal read returns the steered copy. What they cannot show is the end-to-end story across many accesses: that a copy skipped while absent still holds its old value once it returns, that the selector read-back layout matches the documented bit positions, and that a selector write redirects the next access. The bench's scoreboard covers those through directed sequences and a pseudo-random mix checked against its own model.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

  localparam int unsigned SEL_INST_LSB = 0;
  localparam int unsigned SEL_GRP_LSB  = 8;
  localparam int unsigned SEL_BCAST_BIT = 16;
  localparam int unsigned SEL_W        = 17;

  typedef struct packed {
    logic       bcast;
    logic [7:0] grp;
    logic [7:0] inst;
  } steer_t;

  localparam steer_t STEER_RESET = '{bcast: 1'b1, grp: 8'd0, inst: 8'd0};

  function automatic logic [SEL_W-1:0] sel_pack(input steer_t s);
    logic [SEL_W-1:0] w;
    w = '0;
    w[SEL_INST_LSB +: 8] = s.inst;
    w[SEL_GRP_LSB  +: 8] = s.grp;
    w[SEL_BCAST_BIT]     = s.bcast;
    return w;
  endfunction

  function automatic steer_t sel_unpack(input logic [SEL_W-1:0] w);
    steer_t s;
    s.inst  = w[SEL_INST_LSB +: 8];
    s.grp   = w[SEL_GRP_LSB  +: 8];
    s.bcast = w[SEL_BCAST_BIT];
    return s;
  endfunction

  function automatic int unsigned flat_index(input logic [7:0] g, input logic [7:0] i,
                                             input int unsigned n_inst);
    return int'(g) * n_inst + int'(i);
  endfunction

endpackage

// File: rtl/rrb_selector.sv
module rrb_selector
  import rrb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned NUM_INST   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_bits,
  output steer_t            steer
);
  localparam int unsigned GRP_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam int unsigned INST_W = (NUM_INST > 1) ? $clog2(NUM_INST) : 1;
  localparam logic [7:0] GRP_KEEP  = 8'((1 << GRP_W) - 1);
  localparam logic [7:0] INST_KEEP = 8'((1 << INST_W) - 1);

  steer_t incoming;
  steer_t trimmed;

  always_comb begin
    incoming      = sel_unpack(wr_bits);
    trimmed.bcast = incoming.bcast;
    trimmed.grp   = incoming.grp & GRP_KEEP;
    trimmed.inst  = incoming.inst & INST_KEEP;
  end

  always_ff @(posedge clk) begin
    if (rst)        steer <= STEER_RESET;
    else if (wr_en) steer <= trimmed;
  end
endmodule

// File: rtl/rrb_route.sv
module rrb_route
  import rrb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned NUM_INST   = 4,
  parameter int unsigned TOTAL      = NUM_GROUPS * NUM_INST,
  parameter int unsigned IDX_W      = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  steer_t             steer,
  input  logic               bank_wr,
  input  logic [TOTAL-1:0]   avail_mask,
  output logic [TOTAL-1:0]   we_vec,
  output logic [IDX_W-1:0]   tgt_idx,
  output logic               tgt_present,
  output logic               term_wr
);
  logic in_range;

  always_comb begin
    in_range    = (int'(steer.grp) < int'(NUM_GROUPS)) && (int'(steer.inst) < int'(NUM_INST));
    tgt_idx     = in_range ? IDX_W'(flat_index(steer.grp, steer.inst, NUM_INST)) : '0;
    tgt_present = in_range && avail_mask[tgt_idx];
    term_wr     = bank_wr && !steer.bcast && !tgt_present;
  end

  for (genvar k = 0; k < int'(TOTAL); k++) begin : g_we
    logic hit;
    assign hit       = steer.bcast ? 1'b1 : (in_range && (tgt_idx == IDX_W'(k)));
    assign we_vec[k] = bank_wr && hit && avail_mask[k];
  end
endmodule

// File: rtl/rrb_storage.sv
module rrb_storage #(
  parameter int unsigned TOTAL  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [TOTAL-1:0]              we_vec,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [IDX_W-1:0]              rd_idx,
  output logic [TOTAL-1:0][DATA_W-1:0]  copies,
  output logic [DATA_W-1:0]             rd_word
);
  for (genvar k = 0; k < int'(TOTAL); k++) begin : g_copy
    always_ff @(posedge clk) begin
      if (rst)            copies[k] <= '0;
      else if (we_vec[k]) copies[k] <= wdata;
    end
  end

  assign rd_word = copies[rd_idx];
endmodule

// File: rtl/rrb_readback.sv
module rrb_readback
  import rrb_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_hit,
  input  logic              bank_hit,
  input  logic              tgt_present,
  input  steer_t            steer,
  input  logic [DATA_W-1:0] tgt_word,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] next_word;

  always_comb begin
    if (sel_hit)                      next_word = DATA_W'(sel_pack(steer));
    else if (bank_hit && tgt_present) next_word = tgt_word;
    else                              next_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= next_word;
  end
endmodule

// File: rtl/rrb_bank.sv
module rrb_bank
  import rrb_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned NUM_INST   = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] BANK_ADDR  = 8'h40,
  parameter logic [ADDR_W-1:0] STEER_ADDR = 8'h44
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_we,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic [NUM_GROUPS*NUM_INST-1:0] avail_mask,
  output logic [DATA_W-1:0]              bus_rdata
);
  localparam int unsigned TOTAL = NUM_GROUPS * NUM_INST;
  localparam int unsigned IDX_W = (TOTAL > 1) ? $clog2(TOTAL) : 1;

  logic                         bank_hit;
  logic                         sel_hit;
  logic                         bank_wr;
  logic                         sel_wr;
  steer_t                       steer;
  logic [TOTAL-1:0]             we_vec;
  logic [IDX_W-1:0]             tgt_idx;
  logic                         tgt_present;
  logic                         term_wr;
  logic [TOTAL-1:0][DATA_W-1:0] copies;
  logic [DATA_W-1:0]            tgt_word;

  assign bank_hit = (bus_addr == BANK_ADDR);
  assign sel_hit  = (bus_addr == STEER_ADDR);
  assign bank_wr  = bank_hit && bus_we;
  assign sel_wr   = sel_hit && bus_we;

  rrb_selector #(.NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST)) u_sel (
    .clk(clk), .rst(rst), .wr_en(sel_wr),
    .wr_bits(bus_wdata[SEL_W-1:0]), .steer(steer)
  );

  rrb_route #(.NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST), .TOTAL(TOTAL), .IDX_W(IDX_W)) u_route (
    .steer(steer), .bank_wr(bank_wr), .avail_mask(avail_mask),
    .we_vec(we_vec), .tgt_idx(tgt_idx), .tgt_present(tgt_present), .term_wr(term_wr)
  );

  rrb_storage #(.TOTAL(TOTAL), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .we_vec(we_vec), .wdata(bus_wdata),
    .rd_idx(tgt_idx), .copies(copies), .rd_word(tgt_word)
  );

  rrb_readback #(.DATA_W(DATA_W)) u_rb (
    .clk(clk), .rst(rst), .sel_hit(sel_hit), .bank_hit(bank_hit),
    .tgt_present(tgt_present), .steer(steer), .tgt_word(tgt_word), .rdata(bus_rdata)
  );
endmodule

// File: rtl/rrb_bank_chk.sv
module rrb_bank_chk
  import rrb_pkg::*;
#(
  parameter int unsigned TOTAL  = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         bank_hit,
  input logic                         bank_wr,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic [TOTAL-1:0]             avail_mask,
  input steer_t                       steer,
  input logic [TOTAL-1:0]             we_vec,
  input logic [IDX_W-1:0]             tgt_idx,
  input logic                         tgt_present,
  input logic                         sel_hit,
  input logic [TOTAL-1:0][DATA_W-1:0] copies,
  input logic [DATA_W-1:0]            bus_rdata
);
  // R1: selector comes out of reset in broadcast mode at (0,0)
  a_r1_selector_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (steer.bcast && steer.grp == 8'd0 && steer.inst == 8'd0));

  // R4: a unicast write enables at most one copy
  a_r4_unicast_onehot: assert property (@(posedge clk) disable iff (rst)
    (bank_wr && !steer.bcast) |-> $onehot0(we_vec));

  // R7: terminated read yields zero
  a_r7_terminated_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bank_hit && !sel_hit && !tgt_present) |=> (bus_rdata == '0));

  // R6: normal read returns the steered copy
  a_r6_read_steered_copy: assert property (@(posedge clk) disable iff (rst)
    (bank_hit && !sel_hit && tgt_present) |=> (bus_rdata == $past(copies[tgt_idx])));

  for (genvar k = 0; k < int'(TOTAL); k++) begin : g_copy_chk
    // R2: broadcast write lands in every present copy
    a_r2_bcast_loads_present: assert property (@(posedge clk) disable iff (rst)
      (bank_wr && steer.bcast && avail_mask[k]) |=> (copies[k] == $past(bus_wdata)));
    // R3 / R5: absent copies never change
    a_r3_absent_copy_held: assert property (@(posedge clk) disable iff (rst)
      (!avail_mask[k]) |=> (copies[k] == $past(copies[k])));
    // R4: unicast write leaves non-target copies alone
    a_r4_unicast_others_held: assert property (@(posedge clk) disable iff (rst)
      (bank_wr && !steer.bcast && tgt_idx != IDX_W'(k)) |=> (copies[k] == $past(copies[k])));
  end
endmodule

bind rrb_bank rrb_bank_chk #(.TOTAL(TOTAL), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .bank_hit(bank_hit), .bank_wr(bank_wr), .bus_wdata(bus_wdata),
  .avail_mask(avail_mask), .steer(steer), .we_vec(we_vec), .tgt_idx(tgt_idx),
  .tgt_present(tgt_present), .sel_hit(sel_hit), .copies(copies), .bus_rdata(bus_rdata)
);

// File: tb/sim_rrb_bank.sv
module sim_rrb_bank;
  localparam logic [7:0] A_BANK  = 8'h40;
  localparam logic [7:0] A_STEER = 8'h44;
  localparam logic [7:0] A_OTHER = 8'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'hFF;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] avail_mask = 16'hFFFF;
  logic [31:0] bus_rdata;

  always #2 clk = ~clk;

  rrb_bank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .avail_mask(avail_mask), .bus_rdata(bus_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  bit          chk_q[$];
  string       tag_q[$];

  // bench model
  logic [31:0] model [16];
  bit          m_bcast = 1;
  int          m_grp = 0;
  int          m_inst = 0;

  function automatic logic [31:0] sel_word();
    return (32'(m_bcast) << 16) | (32'(m_grp) << 8) | 32'(m_inst);
  endfunction

  function automatic logic [31:0] expect_read(input logic [7:0] a);
    int idx;
    idx = m_grp * 4 + m_inst;
    if (a == A_STEER) return sel_word();
    if (a == A_BANK)  return avail_mask[idx] ? model[idx] : 32'h0;
    return 32'h0;
  endfunction

  task automatic drive(input logic [7:0] a, input logic we, input logic [31:0] d,
                       input bit chk, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_we = we; bus_wdata = d;
    exp_q.push_back(e); chk_q.push_back(chk); tag_q.push_back(t);
  endtask

  task automatic rd(input logic [7:0] a, input string t);
    drive(a, 1'b0, 32'h0, 1'b1, expect_read(a), t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int idx;
    drive(a, 1'b1, d, 1'b0, 32'h0, "");
    idx = m_grp * 4 + m_inst;
    if (a == A_STEER) begin
      m_bcast = d[16]; m_grp = int'(d[9:8]); m_inst = int'(d[1:0]);
    end else if (a == A_BANK) begin
      if (m_bcast) begin
        for (int k = 0; k < 16; k++) if (avail_mask[k]) model[k] = d;
      end else if (avail_mask[idx]) model[idx] = d;
    end
  endtask

  task automatic set_avail(input logic [15:0] m);
    @(negedge clk);
    avail_mask = m; bus_addr = 8'hFF; bus_we = 1'b0;
    exp_q.push_back(32'h0); chk_q.push_back(1'b0); tag_q.push_back("");
  endtask

  task automatic steer_to(input bit b, input int g, input int i);
    wr(A_STEER, (32'(b) << 16) | (32'(g) << 8) | 32'(i));
  endtask

  // monitor: compare registered read data one clock after each presented address
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && exp_q.size() > 0) begin
        logic [31:0] e;
        bit c;
        string t;
        e = exp_q.pop_front(); c = chk_q.pop_front(); t = tag_q.pop_front();
        if (c) begin
          checks++;
          if (bus_rdata !== e) begin
            failures++;
            $display("FAIL %s: rdata=%h expected=%h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int k = 0; k < 16; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(A_STEER, "R1");
    for (int k = 0; k < 16; k++) begin
      steer_to(1, k / 4, k % 4);
      rd(A_BANK, "R1");
    end
    steer_to(1, 0, 0);

    // R2 / R3: broadcast with copy 5 absent
    set_avail(16'hFFDF);
    wr(A_BANK, 32'hA5A5_0001);
    steer_to(1, 1, 1);
    rd(A_BANK, "R7");
    set_avail(16'hFFFF);
    rd(A_BANK, "R3");
    for (int k = 0; k < 16; k++) begin
      steer_to(1, k / 4, k % 4);
      rd(A_BANK, "R2");
    end

    // R4: unicast write to copy 11
    steer_to(0, 2, 3);
    wr(A_BANK, 32'h0000_1234);
    rd(A_BANK, "R4");
    steer_to(0, 2, 2);
    rd(A_BANK, "R4");
    steer_to(1, 2, 3);
    rd(A_BANK, "R6");

    // R5: unicast to absent copy 7 dropped
    set_avail(16'hFF7F);
    steer_to(0, 1, 3);
    wr(A_BANK, 32'hDEAD_BEEF);
    rd(A_BANK, "R7");
    set_avail(16'hFFFF);
    rd(A_BANK, "R5");
    steer_to(0, 1, 2);
    rd(A_BANK, "R5");

    // R8: readback layout and trimming, immediate effect
    wr(A_STEER, 32'hFFFE_FFFF);
    rd(A_STEER, "R8");
    wr(A_STEER, 32'h0001_0302);
    rd(A_STEER, "R8");
    rd(A_BANK, "R8");
    wr(A_STEER, 32'h0000_0201);
    rd(A_BANK, "R8");

    // R9: other address
    wr(A_OTHER, 32'h5555_AAAA);
    rd(A_OTHER, "R9");
    rd(A_BANK, "R9");

    // mixed pseudo-random traffic against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[1:0])
        2'd0: wr(A_STEER, {15'h0, lfsr[9], 6'h0, lfsr[5:4], 6'h0, lfsr[7:6]});
        2'd1: wr(A_BANK, {lfsr, ~lfsr});
        2'd2: rd(A_BANK, "R6");
        default: begin
          if (lfsr[2]) set_avail(lfsr ^ 16'h5A3C);
          else rd(A_STEER, "R8");
        end
      endcase
    end

    set_avail(16'hFFFF);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule